// File: doc/BRIEF.md
# Edge-interval Manchester decoder

This block turns a Manchester-coded serial line into a stream of data bits. It does not recover a clock from the line. It timestamps every rising and falling edge of the input against a free-running counter. It then measures the gap since the previous edge and sorts that gap into one of three classes: a half-bit gap, a full-bit gap or an invalid gap. A small state machine keeps track of whether the last edge fell in the middle of a bit or on a bit boundary. From that, it rebuilds each bit. A rising transition in the middle of a bit means 1, and a falling one means 0. The nominal half-bit length is a fixed parameter.

The number of edges in a packet depends on the data, so the block cannot count edges to find the end of a packet. Instead, a quiet-line timer ends the packet when no edge arrives for a set number of cycles. At that moment the block raises a one-cycle end-of-packet pulse. It also holds a count of the edges it accepted, so the receiver can see how much of the packet arrived. A gap outside both tolerance windows raises a one-cycle error pulse and returns the decoder to idle.

Top module: `mdec_edge_decoder`

## Requirements
- R1: After reset, bit_valid_o, err_o and eop_o are 0 and edge_cnt_o is 0.
- R2: The first edge after idle is taken as the mid-bit edge of the first bit. It emits one bit equal to its direction (rising gives 1, falling gives 0) and sets edge_cnt_o to 1. The line is expected to idle low, so a packet normally starts with a 1.
- R3: Each bit is read from its mid-bit transition: a rising mid-bit edge is 1 and a falling one is 0. A full-bit gap emits the opposite of the previous bit. A half-bit gap that lands on a mid-bit edge emits the same value as the previous bit. A half-bit gap that lands on a boundary emits nothing.
- R4: With half-bit length H cycles, a gap is a half-bit gap when it lies in [H - H/4, H + H/4] and a full-bit gap when it lies in [2H - 2H/4, 2H + 2H/4]. Any gap inside these windows is accepted, even when the timing is uneven.
- R5: When a gap lies outside both windows, or a full-bit gap follows a boundary edge, the block does three things: err_o pulses for one cycle with no bit in that cycle, the offending edge is not counted, and the decoder returns to idle with no end-of-packet pulse afterwards.
- R6: edge_cnt_o counts the edges the block accepted since the packet started. The count depends on the data. At the end-of-packet pulse it equals the number of transitions on the line for that packet, including the return to idle low.
- R7: Once a packet has started, if no edge arrives for TIMEOUT_CYC cycles after the last edge, eop_o pulses for exactly one cycle and the decoder returns to idle.
- R8: If an edge arrives in the same cycle that the timeout would fire, the edge wins. No end-of-packet pulse is raised, and the gap of TIMEOUT_CYC cycles is judged as an invalid gap.
- R9: edge_cnt_o saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous Manchester line, idles low |
| bit_valid_o | output | 1 | One-cycle strobe for a decoded bit |
| bit_data_o | output | 1 | Decoded bit value, valid with bit_valid_o |
| edge_cnt_o | output | ECNT_W | Edges accepted in the current or last packet |
| eop_o | output | 1 | One-cycle end-of-packet pulse from the quiet timer |
| err_o | output | 1 | One-cycle pulse for a rejected interval |

## Verification
An edge and the timeout expiry can land in the same cycle. The bench provokes this by holding the line still for exactly TIMEOUT_CYC cycles after the last edge of a packet before toggling it. The scoreboard then expects an error pulse and no end-of-packet pulse. A second run holds the line one cycle longer. There the expected order is reversed: the end-of-packet pulse comes first with the full edge count, and the late edge then starts a fresh packet.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef enum logic [1:0] {
    IV_HALF = 2'd0,
    IV_FULL = 2'd1,
    IV_BAD  = 2'd2
  } ivl_e;

  // Sort an edge-to-edge gap against windows of +/-25% around h and 2h.
  function automatic ivl_e classify_ivl(input int unsigned gap, input int unsigned h);
    int unsigned f;
    f = 2 * h;
    if (gap >= h - h / 4 && gap <= h + h / 4) return IV_HALF;
    if (gap >= f - f / 4 && gap <= f + f / 4) return IV_FULL;
    return IV_BAD;
  endfunction

endpackage

// File: rtl/mdec_edge_stamp.sv
module mdec_edge_stamp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             edge_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] delta_o
);

  // sh[0], sh[1]: synchronizer; sh[2]: previous synchronized level
  logic [2:0]       sh_q;
  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      now_q  <= '0;
      last_q <= '0;
    end else begin
      sh_q  <= {sh_q[1:0], rx_i};
      now_q <= now_q + 1'b1;
      if (edge_o) last_q <= now_q;
    end
  end

  assign edge_o  = sh_q[2] ^ sh_q[1];
  assign rise_o  = sh_q[1] & ~sh_q[2];
  assign delta_o = now_q - last_q;

endmodule

// File: rtl/mdec_pkt_timer.sv
module mdec_pkt_timer #(
  parameter int unsigned TIMEOUT = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic edge_i,
  output logic hit_o
);

  localparam int unsigned TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  logic [TW-1:0] quiet_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      quiet_q <= '0;
    end else if (edge_i || !active_i) begin
      quiet_q <= '0;
    end else if (quiet_q != LAST) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assign hit_o = active_i && !edge_i && (quiet_q == LAST);

  // R7: the timer only expires after a quiet cycle
  p_hit_after_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(!edge_i));

endmodule

// File: rtl/mdec_bit_fsm.sv
module mdec_bit_fsm
  import mdec_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ECNT_W = 8,
  parameter int unsigned HALF   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              rise_i,
  input  logic [CNT_W-1:0]  delta_i,
  input  logic              hit_i,
  output logic              active_o,
  output logic              bit_valid_o,
  output logic              bit_data_o,
  output logic              err_o,
  output logic              eop_o,
  output logic [ECNT_W-1:0] edge_cnt_o
);

  localparam logic [ECNT_W-1:0] CMAX = '1;

  ivl_e              cls;
  logic              mid_q;      // last accepted edge was mid-bit
  logic              last_bit_q;
  logic [ECNT_W-1:0] cnt_inc;

  assign cls     = classify_ivl(32'(delta_i), HALF);
  assign cnt_inc = (edge_cnt_o == CMAX) ? edge_cnt_o : edge_cnt_o + 1'b1;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      active_o    <= 1'b0;
      mid_q       <= 1'b0;
      last_bit_q  <= 1'b0;
      bit_valid_o <= 1'b0;
      bit_data_o  <= 1'b0;
      err_o       <= 1'b0;
      eop_o       <= 1'b0;
      edge_cnt_o  <= '0;
    end else begin
      bit_valid_o <= 1'b0;
      err_o       <= 1'b0;
      eop_o       <= 1'b0;
      if (edge_i) begin
        if (!active_o) begin
          active_o    <= 1'b1;
          mid_q       <= 1'b1;
          last_bit_q  <= rise_i;
          bit_valid_o <= 1'b1;
          bit_data_o  <= rise_i;
          edge_cnt_o  <= ECNT_W'(1);
        end else begin
          unique case (cls)
            IV_HALF: begin
              mid_q      <= ~mid_q;
              edge_cnt_o <= cnt_inc;
              if (!mid_q) begin
                bit_valid_o <= 1'b1;
                bit_data_o  <= last_bit_q;
              end
            end
            IV_FULL: begin
              if (mid_q) begin
                edge_cnt_o  <= cnt_inc;
                bit_valid_o <= 1'b1;
                bit_data_o  <= ~last_bit_q;
                last_bit_q  <= ~last_bit_q;
              end else begin
                err_o    <= 1'b1;
                active_o <= 1'b0;
              end
            end
            default: begin
              err_o    <= 1'b1;
              active_o <= 1'b0;
            end
          endcase
        end
      end else if (hit_i) begin
        eop_o    <= 1'b1;
        active_o <= 1'b0;
      end
    end
  end

  // R5: an error cycle carries no bit
  p_err_no_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !bit_valid_o);

  // R7: end-of-packet is a single-cycle pulse
  p_eop_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);

  // R6: a packet that ends has accepted at least one edge
  p_eop_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> edge_cnt_o != '0);

  // R3: a full interval from a mid-bit edge flips the bit
  p_full_flips_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && active_o && cls == IV_FULL && mid_q)
      |=> (bit_valid_o && bit_data_o != $past(last_bit_q)));

  // R9: the count holds at its ceiling until a new packet restarts it
  p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_cnt_o == CMAX) |=> (edge_cnt_o == CMAX || edge_cnt_o == ECNT_W'(1)));

endmodule

// File: rtl/mdec_edge_decoder.sv
module mdec_edge_decoder #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned HALF_CYC    = 8,
  parameter int unsigned TIMEOUT_CYC = 48,
  parameter int unsigned ECNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic              bit_valid_o,
  output logic              bit_data_o,
  output logic [ECNT_W-1:0] edge_cnt_o,
  output logic              eop_o,
  output logic              err_o
);

  logic             edge_evt;
  logic             edge_rise;
  logic [CNT_W-1:0] edge_delta;
  logic             timeout_hit;
  logic             pkt_active;

  mdec_edge_stamp #(.CNT_W(CNT_W)) u_stamp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .edge_o  (edge_evt),
    .rise_o  (edge_rise),
    .delta_o (edge_delta)
  );

  mdec_pkt_timer #(.TIMEOUT(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (pkt_active),
    .edge_i   (edge_evt),
    .hit_o    (timeout_hit)
  );

  mdec_bit_fsm #(.CNT_W(CNT_W), .ECNT_W(ECNT_W), .HALF(HALF_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (edge_evt),
    .rise_i      (edge_rise),
    .delta_i     (edge_delta),
    .hit_i       (timeout_hit),
    .active_o    (pkt_active),
    .bit_valid_o (bit_valid_o),
    .bit_data_o  (bit_data_o),
    .err_o       (err_o),
    .eop_o       (eop_o),
    .edge_cnt_o  (edge_cnt_o)
  );

  // R8: an edge in the expiry cycle suppresses end-of-packet
  p_edge_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_evt |=> !eop_o);

endmodule

// File: tb/mdec_edge_decoder_test.sv
`timescale 1ns/1ps
module mdec_edge_decoder_test;

  localparam int HALF    = 8;
  localparam int TIMEOUT = 48;
  localparam int ECNT_W  = 8;
  localparam int CMAX    = (1 << ECNT_W) - 1;

  localparam int K_BIT = 0;
  localparam int K_ERR = 1;
  localparam int K_EOP = 2;

  typedef struct {
    int    kind;
    int    val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b0;
  logic bit_valid, bit_data, eop, err;
  logic [ECNT_W-1:0] edge_cnt;

  int checks = 0;
  int fails  = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  mdec_edge_decoder #(
    .CNT_W(16), .HALF_CYC(HALF), .TIMEOUT_CYC(TIMEOUT), .ECNT_W(ECNT_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .bit_valid_o(bit_valid), .bit_data_o(bit_data),
    .edge_cnt_o(edge_cnt), .eop_o(eop), .err_o(err)
  );

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input int val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop and compare as events appear
  task automatic pop_cmp(input int kind, input int val);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R5 unexpected event kind %0d: actual %0d expected none", kind, val);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.val != val) begin
        fails++;
        $display("FAIL %s event: actual kind %0d val %0d expected kind %0d val %0d",
                 e.req, kind, val, e.kind, e.val);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) pop_cmp(K_BIT, int'(bit_data));
      if (err)       pop_cmp(K_ERR, 0);
      if (eop)       pop_cmp(K_EOP, int'(edge_cnt));
    end
  end

  // Driver: encode bits (first half ~b, second half b), line idles low
  task automatic send_pkt(input logic [255:0] b, input int n, input int jit, input string req);
    int edges = 0;
    int k = 0;
    logic lvl;
    for (int i = 0; i < n; i++) push(K_BIT, int'(b[i]), req);
    for (int i = 0; i < n; i++) begin
      for (int h = 0; h < 2; h++) begin
        lvl = (h == 0) ? ~b[i] : b[i];
        if (lvl != rx) edges++;
        rx = lvl;
        hold(HALF + ((k % 2) ? jit : -jit));
        k++;
      end
    end
    if (rx != 1'b0) edges++;
    push(K_EOP, (edges > CMAX) ? CMAX : edges, "R6");
    rx = 1'b0;
    hold(TIMEOUT + 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    hold(5);
    // R1 reset state
    check("R1", int'(bit_valid), 0, "bit_valid after reset");
    check("R1", int'(err), 0, "err after reset");
    check("R1", int'(eop), 0, "eop after reset");
    check("R1", int'(edge_cnt), 0, "edge_cnt after reset");
    rst_n = 1'b1;
    hold(5);

    // R3 R6 mixed pattern: 1,0,1,1,0,0,1 (bit 0 first)
    send_pkt(256'b1001101, 7, 0, "R3");
    // R6 all ones: 8 edges
    send_pkt(256'b1111, 4, 0, "R6");
    // R4 alternating with uneven halves (6 and 10 cycles)
    send_pkt(256'b0101, 4, 2, "R4");
    // R7 single bit packet
    send_pkt(256'b1, 1, 0, "R7");

    // R5 too-long gap: first edge gives 1, then a 30-cycle gap
    push(K_BIT, 1, "R2"); push(K_ERR, 0, "R5");
    rx = 1'b1; hold(30); rx = 1'b0; hold(TIMEOUT + 20);
    check("R5", int'(edge_cnt), 1, "rejected edge not counted");

    // R5 too-short gap
    push(K_BIT, 1, "R2"); push(K_ERR, 0, "R5");
    rx = 1'b1; hold(3); rx = 1'b0; hold(TIMEOUT + 20);
    check("R5", int'(edge_cnt), 1, "short gap edge not counted");

    // R8 collision: edge exactly TIMEOUT cycles after the last one
    push(K_BIT, 1, "R2"); push(K_ERR, 0, "R8");
    rx = 1'b1; hold(HALF); rx = 1'b0; hold(TIMEOUT); rx = 1'b1; hold(100);
    check("R8", int'(edge_cnt), 2, "count after collision");
    // R2 falling first edge gives 0
    push(K_BIT, 0, "R2"); push(K_EOP, 1, "R7");
    rx = 1'b0; hold(TIMEOUT + 10);

    // R8 one cycle later: timeout first, then fresh packet
    push(K_BIT, 1, "R2"); push(K_EOP, 2, "R8");
    push(K_BIT, 1, "R2"); push(K_EOP, 2, "R8");
    rx = 1'b1; hold(HALF); rx = 1'b0; hold(TIMEOUT + 1);
    rx = 1'b1; hold(HALF); rx = 1'b0; hold(TIMEOUT + 10);

    // R9 saturation: 130 ones give 260 edges
    send_pkt({256{1'b1}}, 130, 0, "R9");
    check("R9", int'(edge_cnt), CMAX, "saturated count");

    check("R7", exp_q.size(), 0, "pending expected events");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule